// File: doc/BRIEF.md
# FIFO-Threshold Interrupt Controller

This block gathers the interrupt sources of a serial bus controller that owns a transmit FIFO and a receive FIFO. Two sources are level conditions computed every cycle from the live FIFO fill counts against software-programmed thresholds: "receive full" and "transmit empty". The other eight are sticky flags, set by one-cycle event pulses from the bus engine and held until software clears them.

Software reaches the block through a small register port with single-cycle writes and reads whose data is registered. It sees the raw status, the masked status, the mask, the two thresholds, both fill counts and the captured abort reason. A sticky flag is cleared by the side effect of a read: each flag has its own clear address, and one shared address clears all of them at once. The interrupt line is the registered OR of the masked status.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the sticky flags, the mask, both threshold fields, the abort reason, `irq` and `reg_rdata` are all zero.
- R2: Raw status bit 0 (receive full) is 1 exactly when `rx_level` is at least the receive threshold field (address 3, bits 7:0) plus one. The effective threshold therefore spans 1 to 256.
- R3: Raw status bit 1 (transmit empty) is 1 exactly when `tx_level` is at most the transmit threshold field (address 4, bits 7:0) plus one.
- R4: Reads of any clear address leave raw bits 0 and 1 unchanged, because those bits follow only the live comparison.
- R5: A pulse on `evt_pulse[k]` sets raw status bit k+2 on the next clock edge. The bit then holds until it is cleared. The bit order is: 0 receive underflow, 1 receive overflow, 2 transmit overflow, 3 transmit abort, 4 activity, 5 stop seen, 6 start seen, 7 general call.
- R6: A read of address 16+k clears sticky raw bit k+2 and no other bit. The read returns zero.
- R7: A read of address 8 clears all eight sticky bits. The read returns zero.
- R8: If an event pulse arrives in the same cycle as a read that clears its bit, the bit stays set.
- R9: Address 1 reads the raw status (address 0, bits 9:0) ANDed with the mask (address 2, bits 9:0, read/write). A mask of 0 masks every source.
- R10: `irq` equals the OR of the masked status one clock later.
- R11: A transmit abort pulse loads `abort_reason` into the abort-reason register (address 7). Clearing the abort flag without a new abort pulse zeroes that register.
- R12: Addresses 5 and 6 return the 9-bit receive and transmit fill counts.
- R13: Writes to any address other than 2, 3 and 4 change no state.
- R14: Read data appears on `reg_rdata` on the edge after `reg_rd` and holds until the next read. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 8 | One-cycle sticky event pulses (bit order in R5) |
| abort_reason | input | 16 | Cause code captured with a transmit abort pulse |
| rx_level | input | 9 | Receive FIFO fill count |
| tx_level | input | 9 | Transmit FIFO fill count |
| reg_addr | input | 5 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe (also triggers clear side effects) |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that event pulses and read strobes are sampled only on the rising clock edge. They also assume that each clear-on-read is a single-cycle strobe, because a held `reg_rd` on a clear address keeps clearing on every cycle. Fill counts may take any 9-bit value, including counts above 256, so the threshold comparisons are exercised past the effective threshold range. The bench drives every input at the falling edge, keeps each read to exactly one cycle, mixes random sparse event bursts with random reads, writes and fill counts, and adds directed runs at threshold fields 0 and 255.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int NSRC = 10;   // total interrupt sources
  localparam int NSTK = 8;    // sticky sources, placed at raw bits 2..9
  localparam int STK_BASE = 2;
  localparam int STK_ABORT = 3; // sticky index of transmit abort

  // register word addresses
  localparam int A_RAW    = 0;
  localparam int A_MSTAT  = 1;
  localparam int A_MASK   = 2;
  localparam int A_RXTHR  = 3;
  localparam int A_TXTHR  = 4;
  localparam int A_RXLVL  = 5;
  localparam int A_TXLVL  = 6;
  localparam int A_ABRT   = 7;
  localparam int A_CLRALL = 8;
  localparam int A_CLR0   = 16;
endpackage

// File: rtl/fic_level_cmp.sv
module fic_level_cmp #(
  parameter int LVL_W = 9,
  parameter int THR_W = 8
) (
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [THR_W-1:0] tx_thr,
  output logic             rx_full,
  output logic             tx_empty
);
  // widen by one bit so that field+1 never wraps
  localparam int CW = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1;

  logic [CW-1:0] rx_eff, tx_eff;

  assign rx_eff = CW'(rx_thr) + CW'(1);
  assign tx_eff = CW'(tx_thr) + CW'(1);

  assign rx_full  = CW'(rx_level) >= rx_eff;
  assign tx_empty = CW'(tx_level) <= tx_eff;
endmodule

// File: rtl/fic_sticky_bank.sv
module fic_sticky_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        stat[k] <= 1'b0;
      else if (ev[k])
        stat[k] <= 1'b1;        // event has priority over clear
      else if (clr[k])
        stat[k] <= 1'b0;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (stat[k] && !clr[k]) |=> stat[k]);                  // R5
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
      ev[k] |=> stat[k]);                                  // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (clr[k] && !ev[k]) |=> !stat[k]);                    // R6
  end
endmodule

// File: rtl/fic_abort_cap.sv
module fic_abort_cap #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev,
  input  logic [W-1:0] reason,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (ev)
      q <= reason;
    else if (clr)
      q <= '0;
  end

  AST_ABRT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ev |=> (q == $past(reason)));                          // R11
endmodule

// File: rtl/fic_csr.sv
module fic_csr
  import fic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int LVL_W  = 9,
  parameter int THR_W  = 8,
  parameter int ABRT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  input  logic [NSRC-1:0]   raw,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [ABRT_W-1:0] abort_q,
  output logic [NSRC-1:0]   mask,
  output logic [THR_W-1:0]  rx_thr,
  output logic [THR_W-1:0]  tx_thr,
  output logic [NSTK-1:0]   clr,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int MAXF = (NSRC > THR_W) ? NSRC : THR_W;

  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:MAXF];

  // writable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      rx_thr <= '0;
      tx_thr <= '0;
    end else if (reg_wr) begin
      case (int'(reg_addr))
        A_MASK:  mask   <= reg_wdata[NSRC-1:0];
        A_RXTHR: rx_thr <= reg_wdata[THR_W-1:0];
        A_TXTHR: tx_thr <= reg_wdata[THR_W-1:0];
        default: ;
      endcase
    end
  end

  // clear-on-read decode, one strobe per sticky source
  for (genvar k = 0; k < NSTK; k++) begin : g_clr
    assign clr[k] = reg_rd && ((int'(reg_addr) == A_CLRALL) ||
                               (int'(reg_addr) == A_CLR0 + k));
  end

  always_comb begin
    rd_mux = '0;
    case (int'(reg_addr))
      A_RAW:   rd_mux[NSRC-1:0]   = raw;
      A_MSTAT: rd_mux[NSRC-1:0]   = raw & mask;
      A_MASK:  rd_mux[NSRC-1:0]   = mask;
      A_RXTHR: rd_mux[THR_W-1:0]  = rx_thr;
      A_TXTHR: rd_mux[THR_W-1:0]  = tx_thr;
      A_RXLVL: rd_mux[LVL_W-1:0]  = rx_level;
      A_TXLVL: rd_mux[LVL_W-1:0]  = tx_level;
      A_ABRT:  rd_mux[ABRT_W-1:0] = abort_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= rd_mux;
  end

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && int'(reg_addr) == A_MASK) |=> (mask == $past(reg_wdata[NSRC-1:0]))); // R9
  AST_RD_MASK_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr && int'(reg_addr) == A_MASK) |=> (reg_rdata[NSRC-1:0] == mask)); // R14
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));                       // R14
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int LVL_W  = 9,
  parameter int THR_W  = 8,
  parameter int ABRT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSTK-1:0]   evt_pulse,
  input  logic [ABRT_W-1:0] abort_reason,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NSRC-1:0]  raw, mask, masked;
  logic [NSTK-1:0]  stk, clr;
  logic [THR_W-1:0] rx_thr, tx_thr;
  logic [ABRT_W-1:0] abort_q;
  logic             rx_full, tx_empty;

  fic_level_cmp #(.LVL_W(LVL_W), .THR_W(THR_W)) u_cmp (
    .rx_level (rx_level),
    .tx_level (tx_level),
    .rx_thr   (rx_thr),
    .tx_thr   (tx_thr),
    .rx_full  (rx_full),
    .tx_empty (tx_empty)
  );

  fic_sticky_bank #(.N(NSTK)) u_stk (
    .clk  (clk),
    .rst  (rst),
    .ev   (evt_pulse),
    .clr  (clr),
    .stat (stk)
  );

  fic_abort_cap #(.W(ABRT_W)) u_abrt (
    .clk    (clk),
    .rst    (rst),
    .ev     (evt_pulse[STK_ABORT]),
    .reason (abort_reason),
    .clr    (clr[STK_ABORT]),
    .q      (abort_q)
  );

  fic_csr #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W),
    .THR_W(THR_W), .ABRT_W(ABRT_W)
  ) u_csr (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .raw       (raw),
    .rx_level  (rx_level),
    .tx_level  (tx_level),
    .abort_q   (abort_q),
    .mask      (mask),
    .rx_thr    (rx_thr),
    .tx_thr    (tx_thr),
    .clr       (clr),
    .reg_rdata (reg_rdata)
  );

  assign raw    = {stk, tx_empty, rx_full};
  assign masked = raw & mask;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |masked;
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (|masked) |=> irq);                                    // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|masked) |=> !irq);                                  // R10
  AST_LEVEL_NOT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr && $stable(rx_level) && rx_full) |=> (rx_full || $changed(rx_level))); // R4
endmodule

// File: tb/fifo_irq_ctrl_test.sv
module fifo_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  evt_pulse;
  logic [15:0] abort_reason;
  logic [8:0]  rx_level, tx_level;
  logic [4:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [7:0]  m_stk;
  logic [9:0]  m_mask;
  logic [7:0]  m_rxt, m_txt;
  logic [15:0] m_abrt;

  always #4 clk = ~clk;   // 125 MHz

  fifo_irq_ctrl uut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .abort_reason(abort_reason),
    .rx_level(rx_level), .tx_level(tx_level), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [9:0] exp_raw();
    logic rf, te;
    rf = int'(rx_level) >= int'(m_rxt) + 1;
    te = int'(tx_level) <= int'(m_txt) + 1;
    return {m_stk, te, rf};
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    case (a)
      0: return 32'(exp_raw());
      1: return 32'(exp_raw() & m_mask);
      2: return 32'(m_mask);
      3: return 32'(m_rxt);
      4: return 32'(m_txt);
      5: return 32'(rx_level);
      6: return 32'(tx_level);
      7: return 32'(m_abrt);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock of stimulus, driven at negedge, checked at the next negedge
  task automatic step(input logic [7:0] ev, input logic [15:0] rsn,
                      input bit rd, input bit wr, input int a,
                      input logic [31:0] wd, input string tag);
    logic [31:0] e_rd;
    logic        e_irq;
    logic [7:0]  clrv;
    e_rd  = exp_read(a);
    e_irq = |(exp_raw() & m_mask);
    evt_pulse = ev; abort_reason = rsn; reg_rd = rd; reg_wr = wr;
    reg_addr = 5'(a); reg_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    clrv = 8'h00;
    if (rd && a == 8) clrv = 8'hff;
    if (rd && a >= 16 && a <= 23) clrv[a-16] = 1'b1;
    if (ev[3]) m_abrt = rsn;
    else if (clrv[3]) m_abrt = 16'h0;
    m_stk = (m_stk & ~clrv) | ev;
    if (wr) begin
      if (a == 2) m_mask = wd[9:0];
      if (a == 3) m_rxt  = wd[7:0];
      if (a == 4) m_txt  = wd[7:0];
    end
    evt_pulse = '0; reg_rd = 1'b0; reg_wr = 1'b0;
    check(irq == e_irq, {tag, " irq"}, 32'(irq), 32'(e_irq));
    if (rd) check(reg_rdata == e_rd, {tag, " rdata"}, reg_rdata, e_rd);
  endtask

  task automatic rd(input int a, input string tag);
    step(8'h00, 16'h0, 1'b1, 1'b0, a, 32'h0, tag);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    step(8'h00, 16'h0, 1'b0, 1'b1, a, d, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; evt_pulse = '0; abort_reason = '0; rx_level = '0; tx_level = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    m_stk = '0; m_mask = '0; m_rxt = '0; m_txt = '0; m_abrt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
    check(reg_rdata == 32'h0, "R1 rdata after reset", reg_rdata, 32'h0);
    rd(0, "R1 raw");                 // only transmit-empty set: 0 <= 1
    check(reg_rdata == 32'h002, "R1 raw literal", reg_rdata, 32'h002);
    rd(2, "R1 mask"); rd(3, "R1 rxthr"); rd(4, "R1 txthr"); rd(7, "R1 abort");

    // R2 receive-full boundaries
    rx_level = 9'd1; rd(0, "R2 thr0 lvl1");
    check(reg_rdata[0] == 1'b1, "R2 lvl1>=1", 32'(reg_rdata[0]), 32'h1);
    rx_level = 9'd0; rd(0, "R2 thr0 lvl0");
    check(reg_rdata[0] == 1'b0, "R2 lvl0", 32'(reg_rdata[0]), 32'h0);
    wr(3, 32'hff, "R2 thr255");
    rx_level = 9'd255; rd(0, "R2 lvl255");
    check(reg_rdata[0] == 1'b0, "R2 255<256", 32'(reg_rdata[0]), 32'h0);
    rx_level = 9'd256; rd(0, "R2 lvl256");
    check(reg_rdata[0] == 1'b1, "R2 256>=256", 32'(reg_rdata[0]), 32'h1);

    // R3 transmit-empty boundaries
    tx_level = 9'd2; rd(0, "R3 thr0 lvl2");
    check(reg_rdata[1] == 1'b0, "R3 2>1", 32'(reg_rdata[1]), 32'h0);
    wr(4, 32'hff, "R3 thr255");
    tx_level = 9'd256; rd(0, "R3 lvl256");
    check(reg_rdata[1] == 1'b1, "R3 256<=256", 32'(reg_rdata[1]), 32'h1);
    tx_level = 9'd257; rd(0, "R3 lvl257");
    check(reg_rdata[1] == 1'b0, "R3 257>256", 32'(reg_rdata[1]), 32'h0);

    // R4 level sources survive clear reads
    rd(8, "R4 clrall"); rd(16, "R4 clr0"); rd(0, "R4 raw after clears");
    check(reg_rdata[0] == 1'b1, "R4 rxfull kept", 32'(reg_rdata[0]), 32'h1);

    // R5 sticky set and hold; R9 masked status; R10 irq
    step(8'h21, 16'h0, 1'b0, 1'b0, 0, 32'h0, "R5 events");
    repeat (3) rd(0, "R5 hold");
    check(reg_rdata[9:2] == 8'h21, "R5 sticky bits", 32'(reg_rdata[9:2]), 32'h21);
    wr(2, 32'h004, "R9 mask write");
    rd(1, "R9 masked");
    check(reg_rdata == 32'h004, "R9 masked literal", reg_rdata, 32'h004);
    check(irq == 1'b1, "R10 irq high", 32'(irq), 32'h1);

    // R6 single clear; R7 clear all
    rd(16, "R6 clear rx-underflow");
    check(reg_rdata == 32'h0, "R6 clear reads zero", reg_rdata, 32'h0);
    rd(0, "R6 other bit kept");
    check(reg_rdata[9:2] == 8'h20, "R6 bits", 32'(reg_rdata[9:2]), 32'h20);
    step(8'hff, 16'h0, 1'b0, 1'b0, 0, 32'h0, "R7 set all");
    rd(8, "R7 clear all"); rd(0, "R7 raw");
    check(reg_rdata[9:2] == 8'h00, "R7 all cleared", 32'(reg_rdata[9:2]), 32'h0);

    // R8 event concurrent with its clear
    step(8'h80, 16'h0, 1'b1, 1'b0, 23, 32'h0, "R8 same cycle");
    rd(0, "R8 raw");
    check(reg_rdata[9] == 1'b1, "R8 bit stays", 32'(reg_rdata[9]), 32'h1);

    // R11 abort reason
    step(8'h08, 16'hbeef, 1'b0, 1'b0, 0, 32'h0, "R11 abort");
    rd(7, "R11 reason");
    check(reg_rdata == 32'h0000beef, "R11 reason literal", reg_rdata, 32'hbeef);
    rd(19, "R11 clear abort"); rd(7, "R11 reason cleared");
    check(reg_rdata == 32'h0, "R11 zeroed", reg_rdata, 32'h0);

    // R12 fill counts
    rx_level = 9'h1a5; tx_level = 9'h0c3;
    rd(5, "R12 rx level"); rd(6, "R12 tx level");
    check(reg_rdata == 32'h0c3, "R12 tx literal", reg_rdata, 32'h0c3);

    // R13 writes to read-only addresses; R14 unmapped read and hold
    wr(0, 32'hffff_ffff, "R13 wr raw"); wr(7, 32'h1234, "R13 wr abort");
    wr(8, 32'hffff, "R13 wr clrall"); wr(17, 32'h1, "R13 wr clr");
    rd(0, "R13 raw unchanged"); rd(7, "R13 abort unchanged");
    rd(12, "R14 unmapped");
    check(reg_rdata == 32'h0, "R14 unmapped zero", reg_rdata, 32'h0);
    wr(2, 32'h3ff, "R14 no read");
    check(reg_rdata == 32'h0, "R14 rdata holds", reg_rdata, 32'h0);

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [7:0] ev;
      int a;
      bit r, w;
      ev = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      a  = int'($urandom % 24);
      r  = ($urandom % 2) == 1;
      w  = ($urandom % 5) == 0;
      if (($urandom % 8) == 0) rx_level = 9'($urandom);
      if (($urandom % 8) == 0) tx_level = 9'($urandom);
      step(ev, 16'($urandom), r, w, a, $urandom, "R9 R10 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule